// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the register bank and interrupt logic of a small color panel controller. A processor reaches it through a 32-bit memory-mapped slave port. Each word sits at a byte offset, and the register index is that offset shifted right by two. Software programs four timing words, the upper and lower frame base addresses, a control word and an interrupt mask through the port. From these writes the block derives the panel width in pixels, the panel height in lines, the pixel depth code and three ordering flags. It drives these straight to the pixel engine.

A frame-tick counter runs only while the controller is both enabled and powered. Each time the counter wraps it raises two status events, next-base and vertical-compare. Software reads the raw status and the masked status, and clears events by writing ones. A single level interrupt follows the masked status in the same cycle that the status or mask changes. A variant parameter selects whether the mask and control words sit at indices 6 and 7 or at 7 and 6. It also selects which identification bytes appear in the top eight words of the window.

Top module: `lcd_regif_top`

## Requirements
- R1: After reset every register is zero: the read data, the interrupt output, the derived width and height, the depth code and all control flags.
- R2: A read request at index i returns its data on bus_rdata one cycle later. Indices 0 to 3 are the timing words, 4 is the upper base and 5 is the lower base; each reads back the last value written to it. Indices 11 and 12 read back the upper and lower base values.
- R3: With VARIANT 0, index 6 is the interrupt mask and index 7 is the control word. With any other VARIANT the two are swapped, for both reads and writes.
- R4: The scan_on output is 1 only when control bit 0 and control bit 11 are both 1. pixel_depth is control bits [3:1]. swap_rb, big_byte and big_pixel are control bits 8, 9 and 10.
- R5: A write to index 0 with value v sets panel_width to ((v & 0xFC) + 4) * 4 in the following cycle.
- R6: A write to index 1 with value v sets panel_height to (v & 0x3FF) + 1 in the following cycle.
- R7: Index 8 reads raw status and index 9 reads raw status AND mask. irq is 1 exactly when that AND is nonzero.
- R8: Writing w to index 10 clears every raw status bit where w is 1, and irq reflects the result in the following cycle.
- R9: Each frame tick sets raw status bit 2 and bit 3. While the unit is enabled, the first tick comes TICK_CYCLES cycles after the control write and then every TICK_CYCLES cycles. Any control write restarts the count. No other raw status bit ever becomes 1.
- R10: While scan_on is 0 no tick occurs, so raw status stays as software left it.
- R11: When a clear write and a tick fall in the same cycle, bits 2 and 3 end up set.
- R12: Indices 1016 to 1023 (byte offsets 0xFE0 to 0xFFC) return the identification bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. With VARIANT 2 the first three bytes are 0x11, 0x11, 0x24 instead.
- R13: Reads of any other index (for example 10, 13 or 128) return 0. Writes to them, and to the identification words, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt from masked status |
| panel_width | output | 11 | Pixels per line derived from timing word 0 |
| panel_height | output | 11 | Lines per panel derived from timing word 1 |
| pixel_depth | output | 3 | Pixel depth code |
| scan_on | output | 1 | Controller enabled and powered |
| swap_rb | output | 1 | Blue-green-red component order |
| big_byte | output | 1 | Big-endian byte order |
| big_pixel | output | 1 | Big-endian pixel order within a byte |

## Verification
The bench drives the first tick to its exact cycle. If the counter is off by one, the interrupt shows up one cycle early or late. The bench also lands a clear write on the same edge as a tick. A design that gives the clear priority loses that frame's events and reads raw status as zero. The bench probes the width formula with the low two bits set and with bits above bit 7 set, and probes the height with values above 0x3FF. Bad masking shows up there as a wrong width or height. Finally, two instances built as different variants share one bus. A mask and control swap that fails turns on the wrong instance, and a bad identification table returns wrong bytes at 0xFE0.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
  localparam int PIX_W = 11;

  // register indices (byte offset >> 2)
  localparam int IX_UP     = 4;
  localparam int IX_LP     = 5;
  localparam int IX_RAW    = 8;
  localparam int IX_MSK    = 9;
  localparam int IX_CLR    = 10;
  localparam int IX_UPCUR  = 11;
  localparam int IX_LPCUR  = 12;
  localparam int N_TIMING  = 4;
  localparam int N_ID      = 8;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_BGR  = 8;
  localparam int CB_BEBY = 9;
  localparam int CB_BEPX = 10;
  localparam int CB_PWR  = 11;

  // status bit positions raised by a frame tick
  localparam int SB_NEXTBASE = 2;
  localparam int SB_VCOMP    = 3;

  function automatic logic [7:0] id_byte(input logic [2:0] k, input logic ext);
    case (k)
      3'd0:    id_byte = ext ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = ext ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcd_frame_tick.sv
module lcd_frame_tick #(
  parameter int TICK_CYCLES = 3333333
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] raw_q,
  output logic [DATA_W-1:0] masked,
  output logic              irq
);
  localparam logic [DATA_W-1:0] TICK_SET =
    (DATA_W'(1) << SB_NEXTBASE) | (DATA_W'(1) << SB_VCOMP);

  logic [DATA_W-1:0] raw_d, mask_d;

  always_comb begin
    raw_d  = raw_q & ~(clr_we ? wdata : '0);
    if (tick) raw_d = raw_d | TICK_SET;   // new events win over a clear
    mask_d = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq    <= |(raw_d & mask_d);
    end
  end

  assign masked = raw_q & mask_q;
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_TIMING-1:0]            tim_we,
  input  logic                           up_we,
  input  logic                           lp_we,
  input  logic                           ctrl_we,
  input  logic [DATA_W-1:0]              wdata,
  output logic [N_TIMING-1:0][DATA_W-1:0] tim_q,
  output logic [DATA_W-1:0]              up_q,
  output logic [DATA_W-1:0]              lp_q,
  output logic [DATA_W-1:0]              ctrl_q,
  output logic [PIX_W-1:0]               width_q,
  output logic [PIX_W-1:0]               height_q
);
  for (genvar k = 0; k < N_TIMING; k++) begin : g_tim
    always_ff @(posedge clk) begin
      if (rst)            tim_q[k] <= '0;
      else if (tim_we[k]) tim_q[k] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q     <= '0;
      lp_q     <= '0;
      ctrl_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
    end else begin
      if (up_we)   up_q   <= wdata;
      if (lp_we)   lp_q   <= wdata;
      if (ctrl_we) ctrl_q <= wdata;
      // 16 pixels per step of bits [7:2], plus one step
      if (tim_we[0]) width_q  <= (PIX_W'(wdata[7:2]) + PIX_W'(1)) << 4;
      if (tim_we[1]) height_q <= PIX_W'(wdata[9:0]) + PIX_W'(1);
    end
  end
endmodule

// File: rtl/lcd_regif_top.sv
module lcd_regif_top
  import lcd_regif_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int VARIANT     = 0,
  parameter int TICK_CYCLES = 3333333
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic [PIX_W-1:0]  panel_width,
  output logic [PIX_W-1:0]  panel_height,
  output logic [2:0]        pixel_depth,
  output logic              scan_on,
  output logic              swap_rb,
  output logic              big_byte,
  output logic              big_pixel
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int ID_BASE = (1 << IDX_W) - N_ID;
  localparam int MASK_IX = (VARIANT == 0) ? 6 : 7;
  localparam int CTRL_IX = (VARIANT == 0) ? 7 : 6;
  localparam bit EXT_ID  = (VARIANT == 2);

  logic [IDX_W-1:0] idx;
  logic             wr_en, in_id, unused_lsb;
  logic [N_TIMING-1:0] tim_we;
  logic up_we, lp_we, ctrl_we, mask_we, clr_we;
  logic tick_w;
  logic [N_TIMING-1:0][DATA_W-1:0] tim_q;
  logic [DATA_W-1:0] up_q, lp_q, ctrl_q, mask_w, raw_w, masked_w, rd_d;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr_en      = bus_sel && bus_wr;
  assign in_id      = (int'(idx) >= ID_BASE);

  for (genvar k = 0; k < N_TIMING; k++) begin : g_twe
    assign tim_we[k] = wr_en && (idx == IDX_W'(k));
  end
  assign up_we   = wr_en && (idx == IDX_W'(IX_UP));
  assign lp_we   = wr_en && (idx == IDX_W'(IX_LP));
  assign ctrl_we = wr_en && (idx == IDX_W'(CTRL_IX));
  assign mask_we = wr_en && (idx == IDX_W'(MASK_IX));
  assign clr_we  = wr_en && (idx == IDX_W'(IX_CLR));

  lcd_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .tim_we(tim_we), .up_we(up_we), .lp_we(lp_we),
    .ctrl_we(ctrl_we), .wdata(bus_wdata), .tim_q(tim_q), .up_q(up_q),
    .lp_q(lp_q), .ctrl_q(ctrl_q), .width_q(panel_width), .height_q(panel_height)
  );

  assign scan_on     = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
  assign pixel_depth = ctrl_q[3:1];
  assign swap_rb     = ctrl_q[CB_BGR];
  assign big_byte    = ctrl_q[CB_BEBY];
  assign big_pixel   = ctrl_q[CB_BEPX];

  lcd_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .run(scan_on), .restart(ctrl_we), .tick(tick_w)
  );

  lcd_irq_unit #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .mask_we(mask_we), .clr_we(clr_we),
    .wdata(bus_wdata), .tick(tick_w), .mask_q(mask_w), .raw_q(raw_w),
    .masked(masked_w), .irq(irq)
  );

  always_comb begin
    rd_d = '0;
    if (in_id) begin
      rd_d = DATA_W'(id_byte(idx[2:0], EXT_ID));
    end else if (int'(idx) < N_TIMING) begin
      rd_d = tim_q[idx[1:0]];
    end else begin
      case (idx)
        IDX_W'(IX_UP), IDX_W'(IX_UPCUR): rd_d = up_q;
        IDX_W'(IX_LP), IDX_W'(IX_LPCUR): rd_d = lp_q;
        IDX_W'(CTRL_IX):                 rd_d = ctrl_q;
        IDX_W'(MASK_IX):                 rd_d = mask_w;
        IDX_W'(IX_RAW):                  rd_d = raw_w;
        IDX_W'(IX_MSK):                  rd_d = masked_w;
        default:                         rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_d;
  end
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk
  import lcd_regif_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  idx,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [PIX_W-1:0]  panel_width,
  input logic [PIX_W-1:0]  panel_height,
  input logic              scan_on,
  input logic              tick,
  input logic [DATA_W-1:0] raw_q,
  input logic [DATA_W-1:0] mask_q
);
  localparam logic [DATA_W-1:0] EVT = DATA_W'(32'hC);
  logic wr_en, rd_en;
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq && raw_q == '0 && panel_width == '0 && bus_rdata == '0));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((raw_q & mask_q) != '0));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(IX_CLR) && !tick) |=> ((raw_q & $past(bus_wdata)) == '0));

  // R9
  tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((raw_q & EVT) == EVT));

  // R9
  raw_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_q & ~EVT) == '0);

  // R10
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !scan_on |-> !tick);

  // R5
  width_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == '0) |=>
      (32'(panel_width) == ((32'($past(bus_wdata)) & 32'hFC) + 32'd4) * 32'd4));

  // R6
  height_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(1)) |=>
      (32'(panel_height) == (32'($past(bus_wdata)) & 32'h3FF) + 32'd1));

  // R13
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_W'(13)) |=> (bus_rdata == '0));
endmodule

bind lcd_regif_top lcd_regif_chk #(.IDX_W(ADDR_W - 2), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .idx(idx),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .panel_width(panel_width), .panel_height(panel_height), .scan_on(scan_on),
  .tick(tick_w), .raw_q(raw_w), .mask_q(mask_w)
);

// File: tb/sim_lcd_regif_top.sv
module sim_lcd_regif_top;
  localparam int TICK = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic irq0, irq1, on0, on1, rb0, rb1, bb0, bb1, bp0, bp1;
  logic [10:0] w0, w1, h0, h1;
  logic [2:0] d0, d1;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_tim [4];
  logic [31:0] m_up = 0, m_lp = 0, m_ctrl = 0, m_mask = 0, m_raw = 0;

  always #2.5 clk = ~clk;

  lcd_regif_top #(.VARIANT(0), .TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .irq(irq0), .panel_width(w0),
    .panel_height(h0), .pixel_depth(d0), .scan_on(on0), .swap_rb(rb0),
    .big_byte(bb0), .big_pixel(bp0));

  lcd_regif_top #(.VARIANT(2), .TICK_CYCLES(TICK)) u1 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .irq(irq1), .panel_width(w1),
    .panel_height(h1), .pixel_depth(d1), .scan_on(on1), .swap_rb(rb1),
    .big_byte(bb1), .big_pixel(bp1));

  function automatic logic [31:0] id_b(input int k, input bit ext);
    case (k)
      0: id_b = ext ? 32'h11 : 32'h10;
      1: id_b = 32'h11;
      2: id_b = ext ? 32'h24 : 32'h04;
      3: id_b = 32'h00;
      4: id_b = 32'h0D;
      5: id_b = 32'hF0;
      6: id_b = 32'h05;
      default: id_b = 32'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_w(input logic [31:0] v);
    exp_w = ((v & 32'hFC) + 32'd4) * 32'd4;
  endfunction

  function automatic logic [31:0] exp_h(input logic [31:0] v);
    exp_h = (v & 32'h3FF) + 32'd1;
  endfunction

  function automatic logic [31:0] exp_rd(input int idx);
    if (idx >= 1016) return id_b(idx - 1016, 1'b0);
    case (idx)
      0, 1, 2, 3: return m_tim[idx];
      4, 11:      return m_up;
      5, 12:      return m_lp;
      6:          return m_mask;
      7:          return m_ctrl;
      8:          return m_raw;
      9:          return m_raw & m_mask;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int idx, input logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(idx * 4); bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (idx)
      0, 1, 2, 3: m_tim[idx] = v;
      4: m_up = v;
      5: m_lp = v;
      6: m_mask = v;
      7: m_ctrl = v;
      10: m_raw = m_raw & ~v;
      default: ;
    endcase
  endtask

  task automatic rd(input int idx, output logic [31:0] r0, output logic [31:0] r1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(idx * 4);
    @(negedge clk);
    bus_sel = 1'b0;
    r0 = rd0; r1 = rd1;
  endtask

  task automatic rd_chk(input int idx, input string tag);
    logic [31:0] a, b;
    rd(idx, a, b);
    chk($sformatf("%s idx=%0d", tag, idx), a, exp_rd(idx));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] a, b, v;
    int seed;
    seed = $urandom(20240607);
    for (int k = 0; k < 4; k++) m_tim[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq0), 0);
    chk("R1 width", 32'(w0), 0);
    chk("R1 height", 32'(h0), 0);
    chk("R1 flags", {28'd0, on0, rb0, bb0, bp0}, 0);
    chk("R1 rdata", rd0, 0);
    rd_chk(7, "R1 ctrl");
    rd_chk(8, "R1 raw");

    // R2 map and mirrors
    for (int k = 0; k < 6; k++) wr(k, $urandom);
    for (int k = 0; k < 6; k++) rd_chk(k, "R2 readback");
    rd_chk(11, "R2 upper mirror");
    rd_chk(12, "R2 lower mirror");

    // R5 / R6 width and height corners
    foreach (m_tim[k]) ;
    wr(0, 32'h0);          chk("R5 width v=0", 32'(w0), exp_w(32'h0));
    wr(0, 32'hFF);         chk("R5 width v=FF", 32'(w0), exp_w(32'hFF));
    wr(0, 32'h1234_5603);  chk("R5 width high bits", 32'(w0), exp_w(32'h1234_5603));
    wr(1, 32'h0);          chk("R6 height v=0", 32'(h0), exp_h(32'h0));
    wr(1, 32'h3FF);        chk("R6 height v=3FF", 32'(h0), exp_h(32'h3FF));
    wr(1, 32'hFFFF_FC00);  chk("R6 height high bits", 32'(h0), exp_h(32'hFFFF_FC00));

    // R4 enable and control fields
    wr(7, 32'h001); chk("R4 enable only", 32'(on0), 0);
    wr(7, 32'h800); chk("R4 power only", 32'(on0), 0);
    wr(7, 32'h801); chk("R4 enable+power", 32'(on0), 1);
    wr(7, 32'h70E);
    chk("R4 fields", {25'd0, d0, rb0, bb0, bp0, on0}, {25'd0, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0});
    wr(7, 32'h0);

    // R3 variant swap
    wr(6, 32'h801);
    chk("R3 variant2 idx6 is control", 32'(on1), 1);
    chk("R3 base idx6 is mask", 32'(on0), 0);
    rd_chk(6, "R3 base mask");
    wr(6, 32'h0);
    chk("R3 variant2 disabled", 32'(on1), 0);

    // R12 identification bytes
    for (int k = 0; k < 8; k++) begin
      rd(1016 + k, a, b);
      chk($sformatf("R12 base id %0d", k), a, id_b(k, 1'b0));
      chk($sformatf("R12 ext id %0d", k), b, id_b(k, 1'b1));
    end

    // R9 first tick timing
    wr(6, 32'hC);
    wr(7, 32'h801);
    repeat (TICK - 1) @(negedge clk);
    chk("R9 no tick yet", 32'(irq0), 0);
    @(negedge clk);
    chk("R9 tick raises irq", 32'(irq0), 1);
    m_raw = 32'hC;
    rd_chk(8, "R9 raw");
    rd_chk(9, "R7 masked");
    wr(10, 32'h4);
    chk("R8 partial clear keeps irq", 32'(irq0), 1);
    rd_chk(8, "R8 raw after partial");
    wr(10, 32'h8);
    chk("R8 full clear drops irq", 32'(irq0), 0);

    // R11 clear on the tick edge
    wr(7, 32'h801);
    repeat (TICK - 1) @(negedge clk);
    wr(10, 32'hF);
    m_raw = 32'hC;
    rd_chk(8, "R11 tick beats clear");

    // R10 disabled: no ticks
    wr(7, 32'h001);
    wr(10, 32'hF);
    repeat (3 * TICK) @(negedge clk);
    chk("R10 irq stays low", 32'(irq0), 0);
    rd_chk(8, "R10 raw stays zero");

    // leave one event pending for the random phase
    wr(7, 32'h801);
    repeat (TICK + 2) @(negedge clk);
    wr(7, 32'h0);
    m_raw = 32'hC;

    // random phase, controller kept off
    for (int it = 0; it < 400; it++) begin
      int idx, sel;
      sel = int'($urandom % 15);
      idx = (sel < 13) ? sel : int'($urandom % 1024);
      if (sel == 14) idx = 13;
      v = $urandom;
      if (idx == 7) v = v & ~32'h800;
      if ($urandom % 2 == 0) begin
        wr(idx, v);
        chk("R7 irq vs model", 32'(irq0), 32'((m_raw & m_mask) != 0));
        chk("R5 width vs model", 32'(w0), exp_w(m_tim[0]));
        chk("R6 height vs model", 32'(h0), exp_h(m_tim[1]));
      end else begin
        rd_chk(idx, "R2/R7/R13 random read");
      end
    end

    // R13 unmapped and id writes ignored
    wr(13, 32'hFFFF_FFFF);
    wr(128, 32'hFFFF_FFFF);
    wr(1016, 32'h0);
    for (int k = 0; k < 13; k++) rd_chk(k, "R13 regs unchanged");
    rd_chk(13, "R13 unmapped read");
    rd_chk(128, "R13 unmapped read");
    rd_chk(1016, "R13 id unchanged");

    finish_run();
  end
endmodule